// File: doc/BRIEF.md
# Lockable Thermal Monitor Register File

This block is the software-visible control and status register file of an on-die thermal monitor. Firmware reaches it over a simple synchronous register bus with an address, a write strobe with write data, and a read strobe whose data comes back one clock later. It holds an 8-bit trip threshold, a 32-bit calibration slope and a shutdown-enable control. It also shows the latest temperature sample as a read-only value. When the sampled temperature is at or above the threshold and shutdown is enabled, it raises a registered shutdown request.

Boot firmware programs the threshold, the slope and the shutdown enable, then sets a one-shot lock. From then until the next reset, none of these three settings can be changed by any bus write. The shutdown enable is covered as well, so software cannot turn off the overheat response after lockdown. Register map (byte offsets): 0x00 threshold, 0x04 slope, 0x08 lock, 0x0C shutdown control, 0x10 temperature.

Top module: `thermal_guard_regs`

## Requirements
- R1: After the active-low synchronous reset, the threshold reads 125 (0x7D), the slope reads 0, the lock reads 0, the shutdown control reads 0, the temperature reads 0, the shutdown output is 0, and read data is 0.
- R2: While unlocked, a write to 0x00 stores wdata[7:0] as the threshold. Reads of 0x00 return the threshold in bits [7:0] and zero in bits [31:8].
- R3: While unlocked, a write to 0x04 stores all 32 bits of the slope, and a read of 0x04 returns them unchanged.
- R4: The lock is bit 0 of 0x08. A write with wdata[0]=1 sets it. Writing wdata[0]=0 never changes it, whether it is clear or set. Bits [31:1] of 0x08 read zero.
- R5: While the lock is set, writes to 0x00, 0x04 and 0x0C leave the threshold, the slope and the shutdown enable unchanged.
- R6: While unlocked, a write to 0x0C stores wdata[1] as the shutdown enable. A read of 0x0C returns it in bit 1, with every other bit zero.
- R7: The register at 0x10 holds the sensor input as sampled at the previous clock edge, in bits [7:0]. Bus writes to 0x10 have no effect on it.
- R8: The shutdown output is 1 in the cycle after one in which the temperature register is at least the threshold and the enable is 1. Otherwise it is 0 in that following cycle.
- R9: Reads of any address other than the five mapped offsets, including unaligned ones, return zero.
- R10: Read data is registered. It carries the selected register's value from before any write in the same cycle, in the cycle after rd is high, and it is zero in the cycle after rd is low.
- R11: Only reset clears a set lock. After reset, the protected settings can be written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| sensor_temp | input | 8 | Temperature sample from the sensor path |
| shutdown_o | output | 1 | Registered overheat shutdown request |

## Verification
The hardest state to reach from the ports is a set lock together with an armed shutdown and a temperature that sits right at the threshold. Only in that state does a blocked attempt to clear the enable show up directly on the shutdown output. The stimulus programs a threshold and the enable, locks, and then sweeps the sensor across the threshold while it tries to rewrite all three protected fields. A reset later in the run shows that only reset releases the lock.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;

   localparam int OFS_LIMIT = 'h00;
   localparam int OFS_CALIB = 'h04;
   localparam int OFS_LOCK  = 'h08;
   localparam int OFS_SHDN  = 'h0C;
   localparam int OFS_TEMP  = 'h10;

   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_LIMIT = 3'd1,
      SEL_CALIB = 3'd2,
      SEL_LOCK  = 3'd3,
      SEL_SHDN  = 3'd4,
      SEL_TEMP  = 3'd5
   } reg_sel_t;

endpackage

// File: rtl/tg_decode.sv
module tg_decode
   import thermal_guard_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);

   always_comb begin
      sel = SEL_NONE;
      if (addr == ADDR_W'(OFS_LIMIT))      sel = SEL_LIMIT;
      else if (addr == ADDR_W'(OFS_CALIB)) sel = SEL_CALIB;
      else if (addr == ADDR_W'(OFS_LOCK))  sel = SEL_LOCK;
      else if (addr == ADDR_W'(OFS_SHDN))  sel = SEL_SHDN;
      else if (addr == ADDR_W'(OFS_TEMP))  sel = SEL_TEMP;
   end

endmodule

// File: rtl/tg_lock_cell.sv
module tg_lock_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   output logic locked_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)       locked_q <= 1'b0;
      else if (set_req) locked_q <= 1'b1;
   end

   // R4: once set, only reset may clear the lock
   assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> locked_q);

endmodule

// File: rtl/tg_cfg_bank.sv
module tg_cfg_bank #(
   parameter int DATA_W    = 32,
   parameter int TEMP_W    = 8,
   parameter int LIMIT_RST = 125,
   parameter int CALIB_RST = 0,
   parameter int SHDN_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic              wr_limit,
   input  logic              wr_calib,
   input  logic              wr_shdn,
   input  logic [DATA_W-1:0] wdata,
   output logic [TEMP_W-1:0] limit_q,
   output logic [DATA_W-1:0] calib_q,
   output logic              shdn_en_q
);

   logic open_w;
   assign open_w = !locked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         limit_q   <= TEMP_W'(LIMIT_RST);
         calib_q   <= DATA_W'(CALIB_RST);
         shdn_en_q <= 1'b0;
      end else begin
         if (wr_limit && open_w) limit_q   <= wdata[TEMP_W-1:0];
         if (wr_calib && open_w) calib_q   <= wdata;
         if (wr_shdn  && open_w) shdn_en_q <= wdata[SHDN_BIT];
      end
   end

   // R5: protected fields do not move while locked
   assert_limit_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(limit_q));
   assert_calib_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(calib_q));
   assert_enable_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(shdn_en_q));

endmodule

// File: rtl/tg_read_port.sv
module tg_read_port
   import thermal_guard_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int TEMP_W    = 8,
   parameter int SHDN_BIT  = 1,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  reg_sel_t          sel,
   input  logic [TEMP_W-1:0] limit,
   input  logic [DATA_W-1:0] calib,
   input  logic              locked,
   input  logic              shdn_en,
   input  logic [TEMP_W-1:0] temp,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] word;

   always_comb begin
      word = '0;
      case (sel)
         SEL_LIMIT: word = DATA_W'(limit);
         SEL_CALIB: word = calib;
         SEL_LOCK:  word[0] = locked;
         SEL_SHDN:  word[SHDN_BIT] = shdn_en;
         SEL_TEMP:  word = DATA_W'(temp);
         default:   word = '0;
      endcase
   end

   generate
      if (IDLE_ZERO) begin : g_idle_zero
         always_ff @(posedge clk) begin
            if (!rst_n)     rdata <= '0;
            else if (rd_en) rdata <= word;
            else            rdata <= '0;
         end
         // R10: no read strobe, no data
         assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> (rdata == '0));
      end else begin : g_idle_hold
         always_ff @(posedge clk) begin
            if (!rst_n)     rdata <= '0;
            else if (rd_en) rdata <= word;
         end
      end
   endgenerate

endmodule

// File: rtl/thermal_guard_regs.sv
module thermal_guard_regs
   import thermal_guard_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int TEMP_W    = 8,
   parameter int LIMIT_RST = 125,
   parameter int SHDN_BIT  = 1,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [TEMP_W-1:0] sensor_temp,
   output logic              shutdown_o
);

   localparam int TEMP_MAX = (1 << TEMP_W) - 1;

   generate
      if (TEMP_W < 1 || TEMP_W > DATA_W) begin : g_bad_temp_w
         $error("TEMP_W must lie in 1..DATA_W");
      end
      if (SHDN_BIT < 1 || SHDN_BIT >= DATA_W) begin : g_bad_shdn_bit
         $error("SHDN_BIT must lie in 1..DATA_W-1");
      end
      if (LIMIT_RST < 0 || LIMIT_RST > TEMP_MAX) begin : g_bad_limit
         $error("LIMIT_RST does not fit in TEMP_W bits");
      end
      if (ADDR_W < 5) begin : g_bad_addr_w
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   reg_sel_t          sel;
   logic              locked;
   logic [TEMP_W-1:0] limit_q;
   logic [DATA_W-1:0] calib_q;
   logic              shdn_en_q;
   logic [TEMP_W-1:0] temp_q;
   logic              lock_set;

   tg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign lock_set = bus_wr && (sel == SEL_LOCK) && bus_wdata[0];

   tg_lock_cell u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  (lock_set),
      .locked_q (locked)
   );

   tg_cfg_bank #(
      .DATA_W    (DATA_W),
      .TEMP_W    (TEMP_W),
      .LIMIT_RST (LIMIT_RST),
      .CALIB_RST (0),
      .SHDN_BIT  (SHDN_BIT)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .locked    (locked),
      .wr_limit  (bus_wr && (sel == SEL_LIMIT)),
      .wr_calib  (bus_wr && (sel == SEL_CALIB)),
      .wr_shdn   (bus_wr && (sel == SEL_SHDN)),
      .wdata     (bus_wdata),
      .limit_q   (limit_q),
      .calib_q   (calib_q),
      .shdn_en_q (shdn_en_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         temp_q     <= '0;
         shutdown_o <= 1'b0;
      end else begin
         temp_q     <= sensor_temp;
         shutdown_o <= shdn_en_q && (temp_q >= limit_q);
      end
   end

   tg_read_port #(
      .DATA_W    (DATA_W),
      .TEMP_W    (TEMP_W),
      .SHDN_BIT  (SHDN_BIT),
      .IDLE_ZERO (IDLE_ZERO)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (bus_rd),
      .sel     (sel),
      .limit   (limit_q),
      .calib   (calib_q),
      .locked  (locked),
      .shdn_en (shdn_en_q),
      .temp    (temp_q),
      .rdata   (bus_rdata)
   );

   // R7: the temperature register tracks the sensor with one cycle of delay
   assert_temp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (temp_q == $past(sensor_temp)));
   // R8: trip condition raises the shutdown request on the next cycle
   assert_trip_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_en_q && (temp_q >= limit_q)) |=> shutdown_o);
   assert_trip_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(shdn_en_q && (temp_q >= limit_q)) |=> !shutdown_o);

endmodule

// File: tb/thermal_guard_regs_test.sv
module thermal_guard_regs_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [7:0]  sensor_temp = '0;
   logic        shutdown_o;

   int vectors = 0;
   int miscompares = 0;

   // reference state
   logic [7:0]  m_limit = 8'd125;
   logic [31:0] m_calib = '0;
   logic        m_lock = 1'b0;
   logic        m_en = 1'b0;
   logic [7:0]  m_temp = '0;
   logic        m_shdn = 1'b0;
   logic [31:0] m_rdata = '0;

   always #5 clk = ~clk;

   thermal_guard_regs uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_rd      (bus_rd),
      .bus_rdata   (bus_rdata),
      .sensor_temp (sensor_temp),
      .shutdown_o  (shutdown_o)
   );

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h00:   return {24'd0, m_limit};
         8'h04:   return m_calib;
         8'h08:   return {31'd0, m_lock};
         8'h0C:   return {30'd0, m_en, 1'b0};
         8'h10:   return {24'd0, m_temp};
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_edge();
      logic [31:0] nr;
      logic        ns;
      if (!rst_n) begin
         m_limit = 8'd125; m_calib = '0; m_lock = 1'b0; m_en = 1'b0;
         m_temp = '0; m_shdn = 1'b0; m_rdata = '0;
      end else begin
         nr = bus_rd ? model_read(bus_addr) : 32'd0;
         ns = m_en && (m_temp >= m_limit);
         m_temp = sensor_temp;
         if (bus_wr) begin
            case (bus_addr)
               8'h00: if (!m_lock) m_limit = bus_wdata[7:0];
               8'h04: if (!m_lock) m_calib = bus_wdata;
               8'h08: if (bus_wdata[0]) m_lock = 1'b1;
               8'h0C: if (!m_lock) m_en = bus_wdata[1];
               default: ;
            endcase
         end
         m_rdata = nr;
         m_shdn = ns;
      end
   endtask

   task automatic tick(input string req);
      @(posedge clk);
      model_edge();
      #2;
      vectors++;
      if (bus_rdata !== m_rdata || shutdown_o !== m_shdn) begin
         miscompares++;
         $display("FAIL %s: rdata=%h expected %h, shutdown=%b expected %b",
                  req, bus_rdata, m_rdata, shutdown_o, m_shdn);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick(req);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string req);
      bus_addr = a; bus_rd = 1'b1;
      tick(req);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) tick(req);
   endtask

   initial begin
      // R1: reset state
      rst_n = 1'b0;
      idle(2, "R1");
      rst_n = 1'b1;
      idle(1, "R1");
      rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1");
      rd(8'h0C, "R1"); rd(8'h10, "R1");

      // R2: threshold field, upper bits dropped
      wr(8'h00, 32'hFFFF_FF3C, "R2");
      rd(8'h00, "R2");
      // R3: full-width slope
      wr(8'h04, 32'hDEAD_BEEF, "R3");
      rd(8'h04, "R3");
      wr(8'h04, 32'h1234_5678, "R3");
      rd(8'h04, "R3");
      // R6: enable bit only
      wr(8'h0C, 32'hFFFF_FFFD, "R6");
      rd(8'h0C, "R6");
      wr(8'h0C, 32'hFFFF_FFFF, "R6");
      rd(8'h0C, "R6");

      // R7: sensor tracking, writes ignored
      sensor_temp = 8'd42;
      idle(1, "R7");
      wr(8'h10, 32'h0000_00FF, "R7");
      rd(8'h10, "R7");
      sensor_temp = 8'd17;
      rd(8'h10, "R7");
      rd(8'h10, "R7");

      // R9: unmapped and unaligned offsets
      rd(8'h14, "R9"); rd(8'h0E, "R9"); rd(8'h01, "R9"); rd(8'hFC, "R9");

      // R10: read in the same cycle as a write sees the old value
      bus_rd = 1'b1;
      wr(8'h04, 32'hCAFE_0001, "R10");
      bus_rd = 1'b0;
      rd(8'h04, "R10");
      idle(1, "R10");

      // R8: sweep across threshold 60 with enable set
      for (int t = 57; t <= 63; t++) begin
         sensor_temp = 8'(t);
         idle(1, "R8");
      end
      sensor_temp = 8'd59;
      idle(3, "R8");
      sensor_temp = 8'd60;
      idle(3, "R8");
      wr(8'h0C, 32'h0, "R8");
      idle(2, "R8");
      wr(8'h0C, 32'h2, "R8");
      idle(2, "R8");

      // R4: zero write leaves clear lock clear; then set; zero cannot clear
      wr(8'h08, 32'hFFFF_FFFE, "R4");
      rd(8'h08, "R4");
      wr(8'h08, 32'hFFFF_FFFF, "R4");
      rd(8'h08, "R4");
      wr(8'h08, 32'h0, "R4");
      rd(8'h08, "R4");

      // R5: protected fields frozen, shutdown stays armed
      wr(8'h00, 32'h0000_00FF, "R5");
      wr(8'h04, 32'h0, "R5");
      wr(8'h0C, 32'h0, "R5");
      rd(8'h00, "R5"); rd(8'h04, "R5"); rd(8'h0C, "R5");
      sensor_temp = 8'd200;
      idle(2, "R5");
      sensor_temp = 8'd10;
      idle(2, "R5");
      sensor_temp = 8'd60;
      idle(2, "R5");

      // R11: reset releases lock, fields writable again
      rst_n = 1'b0;
      idle(1, "R11");
      rst_n = 1'b1;
      rd(8'h08, "R11");
      rd(8'h00, "R11");
      wr(8'h00, 32'h0000_0000, "R11");
      wr(8'h0C, 32'h2, "R11");
      rd(8'h00, "R11");
      sensor_temp = 8'd0;
      idle(3, "R11");
      sensor_temp = 8'd255;
      wr(8'h00, 32'h0000_00FF, "R11");
      idle(3, "R11");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #2000000;
      miscompares++;
      $display("FAIL timeout: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule